// File: doc/BRIEF.md
# Parallel ATA Strobe Timing Generator

This block produces the read and write strobes of one parallel ATA channel for register (task-file) accesses and for PIO or multiword DMA data cycles. Each of the two devices on the channel owns a 32-bit timing word. Software loads the words through a byte-addressed write port. Each word packs separate setup, active and recovery lengths for command accesses and for data accesses.

When a request is accepted, the block takes a snapshot of the selected device's word and picks the command or the data fields. It then plays out three phases. A setup phase holds both strobes high. An active phase drives the read or write strobe low. A recovery phase holds both strobes high again, and `cycle_done` marks its last clock. A request that arrives in that last clock for the same device and access class continues the burst: it skips the setup phase and reuses the held timing.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset both strobes are high, `cycle_done` is low and `req_ready` is high. Both timing words reset to zero, so every phase then lasts one clock.
- R2: A write with `cfg_we` high loads device d's word only when `cfg_addr` equals CFG_BASE + 4*(d + 2*CHAN), which is 0x40 for device 0 and 0x44 for device 1 by default. A write to any other address changes no word.
- R3: A data access (`req_cmd`=0) runs a setup phase of word[24:22]+1 clocks, an active phase of word[8:4]+1 clocks and a recovery phase of word[3:0]+1 clocks.
- R4: A command access (`req_cmd`=1) runs a setup phase of word[27:25]+1 clocks, an active phase of word[17:13]+1 clocks and a recovery phase of word[12:9]+1 clocks.
- R5: In the active phase, `req_write`=0 drives `dior_n` low and `req_write`=1 drives `diow_n` low. The other strobe stays high, and both strobes are high in every other phase.
- R6: `cycle_done` is high for exactly the last clock of each recovery phase and low at all other times.
- R7: `req_ready` is high only while the block is idle or in the `cycle_done` clock. A request made while `req_ready` is low is ignored.
- R8: A request accepted in the `cycle_done` clock with the same device and access class as the running cycle starts directly with the active phase. It uses the timing captured at the start of the burst. Its direction may differ.
- R9: A request accepted in the `cycle_done` clock with a different device or access class starts a new cycle with a setup phase and a freshly captured word.
- R10: A timing word written while a cycle or burst is in progress does not change that cycle or burst. It applies from the next cycle that starts with a setup phase.
- R11: Word bits 31:28 and 21:18 have no effect on the strobe waveforms.
- R12: `req_dev` selects which device's word a fresh cycle captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_addr | input | ADDR_W | Byte address of the word written |
| cfg_wdata | input | 32 | Timing word value |
| req_valid | input | 1 | Transfer cycle request |
| req_cmd | input | 1 | 1 = task-file register access, 0 = data access |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| req_dev | input | DEV_W | Device select |
| req_ready | output | 1 | Request is taken in this clock if valid |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| cycle_done | output | 1 | Last clock of a cycle's recovery phase |

## Verification
A wrong phase counter or phase state shows at the strobes within one clock: an edge moves early or late against the reference model, or `cycle_done` appears in the wrong clock. A wrong held snapshot or burst-continuation decision appears as a setup phase inserted or dropped at the next cycle boundary. A misdecoded configuration address is seen at the first cycle started after the write. The bench compares both strobes, `cycle_done` and `req_ready` with the model on every clock, so the first wrong cycle is reported.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 5;
    // field positions inside a timing word
    localparam int DHI_LSB  = 0;
    localparam int HI_W     = 4;
    localparam int DLO_LSB  = 4;
    localparam int LO_W     = 5;
    localparam int CHI_LSB  = 9;
    localparam int CLO_LSB  = 13;
    localparam int DPRE_LSB = 22;
    localparam int CPRE_LSB = 25;
    localparam int PRE_W    = 3;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOVER} phase_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [LO_W-1:0]  low;
        logic [HI_W-1:0]  high;
    } phase_set_t;
endpackage

// File: rtl/ata_tword_bank.sv
module ata_tword_bank
    import ata_strobe_pkg::*;
#(
    parameter int                 NUM_DEV    = 2,
    parameter int                 ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]  CFG_BASE   = 'h40,
    parameter int                 CHAN       = 0,
    parameter logic [WORD_W-1:0]  RESET_WORD = '0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  logic [WORD_W-1:0]                 cfg_wdata,
    output logic [NUM_DEV-1:0][WORD_W-1:0]    words
);
    logic [NUM_DEV-1:0][WORD_W-1:0] words_d, words_q;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(CFG_BASE + 4 * (g + NUM_DEV * CHAN));
        always_comb begin
            words_d[g] = words_q[g];
            if (cfg_we && (cfg_addr == SLOT_ADDR))
                words_d[g] = cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) words_q <= {NUM_DEV{RESET_WORD}};
        else        words_q <= words_d;
    end

    assign words = words_q;
endmodule

// File: rtl/ata_field_mux.sv
module ata_field_mux
    import ata_strobe_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              use_cmd,
    output phase_set_t        set
);
    logic unused_bits;
    assign unused_bits = ^{word[31:28], word[21:18]};

    always_comb begin
        if (use_cmd) begin
            set.pre  = word[CPRE_LSB +: PRE_W];
            set.low  = word[CLO_LSB  +: LO_W];
            set.high = word[CHI_LSB  +: HI_W];
        end else begin
            set.pre  = word[DPRE_LSB +: PRE_W];
            set.low  = word[DLO_LSB  +: LO_W];
            set.high = word[DHI_LSB  +: HI_W];
        end
    end
endmodule

// File: rtl/ata_strobe_seq.sv
module ata_strobe_seq
    import ata_strobe_pkg::*;
#(
    parameter int DEV_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_cmd,
    input  logic             req_write,
    input  logic [DEV_W-1:0] req_dev,
    input  phase_set_t       fresh_set,
    output logic             req_ready,
    output logic             dior_n,
    output logic             diow_n,
    output logic             cycle_done
);
    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        phase_set_t         set;
        logic               wr;
        logic               cmd;
        logic [DEV_W-1:0]   dev;
    } seq_t;

    seq_t st_d, st_q;
    logic done_c, ready_c, accept_c, cont_c;

    always_comb begin
        st_d     = st_q;
        done_c   = (st_q.ph == PH_RECOVER) && (st_q.cnt == '0);
        ready_c  = (st_q.ph == PH_IDLE) || done_c;
        accept_c = req_valid && ready_c;
        cont_c   = done_c && (req_dev == st_q.dev) && (req_cmd == st_q.cmd);

        case (st_q.ph)
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_ACTIVE;
                    st_d.cnt = CNT_W'(st_q.set.low);
                end else st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_ACTIVE: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_RECOVER;
                    st_d.cnt = CNT_W'(st_q.set.high);
                end else st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_RECOVER: begin
                if (st_q.cnt == '0) st_d.ph = PH_IDLE;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
            default: ;
        endcase

        if (accept_c) begin
            st_d.wr  = req_write;
            st_d.cmd = req_cmd;
            st_d.dev = req_dev;
            if (cont_c) begin
                st_d.ph  = PH_ACTIVE;
                st_d.cnt = CNT_W'(st_q.set.low);
            end else begin
                st_d.set = fresh_set;
                st_d.ph  = PH_SETUP;
                st_d.cnt = CNT_W'(fresh_set.pre);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, cnt: '0, set: '0, wr: 1'b0, cmd: 1'b0, dev: '0};
        else        st_q <= st_d;
    end

    assign req_ready  = ready_c;
    assign cycle_done = done_c;
    assign dior_n     = !((st_q.ph == PH_ACTIVE) && !st_q.wr);
    assign diow_n     = !((st_q.ph == PH_ACTIVE) &&  st_q.wr);

    AST_FRESH_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && req_valid) |=> (dior_n && diow_n)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done); // R6
    AST_DONE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (dior_n && diow_n)); // R6
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready) |=> ($stable(st_q.dev) && $stable(st_q.cmd))); // R7
    AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE && !cycle_done) |=> $stable(st_q.set)); // R10
endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
    import ata_strobe_pkg::*;
#(
    parameter int                 NUM_DEV    = 2,
    parameter int                 ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]  CFG_BASE   = 'h40,
    parameter int                 CHAN       = 0,
    parameter logic [WORD_W-1:0]  RESET_WORD = '0,
    localparam int                DEV_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic              req_cmd,
    input  logic              req_write,
    input  logic [DEV_W-1:0]  req_dev,
    output logic              req_ready,
    output logic              dior_n,
    output logic              diow_n,
    output logic              cycle_done
);
    logic [NUM_DEV-1:0][WORD_W-1:0] words;
    phase_set_t                     fresh_set;

    ata_tword_bank #(
        .NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE),
        .CHAN(CHAN), .RESET_WORD(RESET_WORD)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .words(words)
    );

    ata_field_mux u_mux (
        .word(words[req_dev]), .use_cmd(req_cmd), .set(fresh_set)
    );

    ata_strobe_seq #(.DEV_W(DEV_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_write(req_write), .req_dev(req_dev), .fresh_set(fresh_set),
        .req_ready(req_ready), .dior_n(dior_n), .diow_n(diow_n),
        .cycle_done(cycle_done)
    );
endmodule

// File: tb/sim_ata_strobe_gen.sv
module sim_ata_strobe_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_cmd = 1'b0;
    logic        req_write = 1'b0;
    logic        req_dev = 1'b0;
    logic        req_ready, dior_n, diow_n, cycle_done;

    int n_chk = 0;
    int n_fail = 0;
    string cur_tag = "R1";

    // model: per-cycle expected {read_low, write_low, done}
    logic [2:0]  mq[$];
    logic [31:0] m_words[2];
    logic [31:0] m_snap = '0;
    logic        m_dev = 1'b0;
    logic        m_cmd = 1'b0;

    ata_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_write(req_write), .req_dev(req_dev), .req_ready(req_ready),
        .dior_n(dior_n), .diow_n(diow_n), .cycle_done(cycle_done)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin : model
        logic [2:0]  e;
        logic        rdy, had_done;
        logic [31:0] w;
        int          p, l, h;
        e        = (mq.size() > 0) ? mq[0] : 3'b000;
        had_done = (mq.size() == 1) && mq[0][0];
        rdy      = (mq.size() == 0) || had_done;
        chk(dior_n, !e[2], cur_tag, "dior_n");
        chk(diow_n, !e[1], cur_tag, "diow_n");
        chk(cycle_done, e[0], "R6", "cycle_done");
        chk(req_ready, rdy, "R7", "req_ready");
        if (mq.size() > 0) void'(mq.pop_front());
        if (rst_n && req_valid && rdy) begin
            if (!(had_done && req_dev == m_dev && req_cmd == m_cmd)) begin
                m_snap = m_words[req_dev];
                w = m_snap;
                p = req_cmd ? ((w >> 25) & 7) : ((w >> 22) & 7);
                for (int i = 0; i <= p; i++) mq.push_back(3'b000);
            end
            w = m_snap;
            l = req_cmd ? ((w >> 13) & 31) : ((w >> 4) & 31);
            h = req_cmd ? ((w >> 9) & 15) : (w & 15);
            for (int i = 0; i <= l; i++) mq.push_back(req_write ? 3'b010 : 3'b100);
            for (int i = 0; i < h; i++) mq.push_back(3'b000);
            mq.push_back(3'b001);
            m_dev = req_dev;
            m_cmd = req_cmd;
        end
        if (rst_n && cfg_we) begin
            for (int d = 0; d < 2; d++)
                if (cfg_addr == 8'(8'h40 + 4 * d)) m_words[d] = cfg_wdata;
        end
    end

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic issue(input logic dv, input logic cm, input logic wr);
        req_valid = 1'b1; req_dev = dv; req_cmd = cm; req_write = wr;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (mq.size() != 0) @(negedge clk);
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        m_words[0] = '0;
        m_words[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dior_n, 1'b1, "R1", "reset dior_n");
        chk(diow_n, 1'b1, "R1", "reset diow_n");
        chk(cycle_done, 1'b0, "R1", "reset cycle_done");
        chk(req_ready, 1'b1, "R1", "reset req_ready");
        @(posedge clk); #1; rst_n = 1'b1;
        // R1: zero words give one-clock phases
        cur_tag = "R1";
        issue(1'b0, 1'b0, 1'b0); wait_idle();

        // R3 R11: data fields, flag bits set
        cur_tag = "R3 R11";
        cfg_write(8'h40, 32'hF03C_0000 | (32'd2 << 22) | (32'd3 << 4) | 32'd1);
        cfg_write(8'h44, (32'd1 << 25) | (32'd4 << 13) | (32'd2 << 9) | (32'd6 << 22) | (32'd5 << 4) | 32'd2);
        issue(1'b0, 1'b0, 1'b0); wait_idle();

        // R4 R12 R5: command fields of device 1, write strobe
        cur_tag = "R4 R12 R5";
        issue(1'b1, 1'b1, 1'b1); wait_idle();
        issue(1'b1, 1'b0, 1'b0); wait_idle();

        // R8 R7: burst continuation, requests held while busy
        cur_tag = "R8 R7";
        issue(1'b0, 1'b0, 1'b1);
        issue(1'b0, 1'b0, 1'b1);
        issue(1'b0, 1'b0, 1'b0);
        wait_idle();

        // R9: device or class change restarts with setup
        cur_tag = "R9";
        issue(1'b0, 1'b0, 1'b0);
        issue(1'b1, 1'b0, 1'b0);
        issue(1'b1, 1'b1, 1'b0);
        wait_idle();

        // R10: word written mid-cycle
        cur_tag = "R10";
        issue(1'b0, 1'b0, 1'b0);
        cfg_write(8'h40, (32'd1 << 22) | (32'd7 << 4) | 32'd3);
        issue(1'b0, 1'b0, 1'b0);
        wait_idle();
        issue(1'b0, 1'b0, 1'b1); wait_idle();

        // R2: writes to unrelated addresses ignored
        cur_tag = "R2";
        cfg_write(8'h48, 32'h00FF_FFFF);
        cfg_write(8'h41, 32'h00FF_FFFF);
        cfg_write(8'h00, 32'h00FF_FFFF);
        issue(1'b0, 1'b0, 1'b0);
        issue(1'b1, 1'b1, 1'b0);
        wait_idle();

        // R6: zero timing burst, done every cycle
        cur_tag = "R6";
        cfg_write(8'h40, 32'h0);
        for (int k = 0; k < 4; k++) issue(1'b0, 1'b0, k[0]);
        wait_idle();

        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule